// File: doc/BRIEF.md
# Clock Output Parking and Power-Down Sequencer

This block sits between free-running clock sources and the clock pins of a system clock generator. Each output has its own source clock and its own enable bit. The block passes the source through, or parks the output LOW. Parking and restarting happen only while that source is LOW, so no output ever emits a short pulse.

A single asynchronous active-low power-down request is synchronized into the CPU-clock domain. It takes effect only after two consecutive synchronized LOW samples. Every output then parks at its own next falling edge, and the PLL-enable lines drop a fixed number of CPU cycles later. When the request is removed, the PLLs are enabled first. The outputs restart only after a programmable number of reference-clock cycles has elapsed. A test-mode input three-states all clock outputs by dropping their output enables.

Top module: `clk_park_unit`

## Requirements
- R1: While `rst_ni` is LOW, every `clk_o` bit is LOW, every `pll_en_o` bit is 1, and every `clk_oe_o` bit is 1 when `test_mode_i` is 0.
- R2: A `pwrdn_ni` LOW that is captured by only one CPU rising edge is ignored: `pll_en_o` stays 1 and the CPU-sourced output keeps toggling.
- R3: Suppose `pwrdn_ni` is LOW at CPU rising edges k and k+1. The output sourced by the CPU clock still pulses HIGH in the cycle that starts at edge k+2 and is LOW from edge k+3 onward. Every other output is LOW after its next source falling edge, and all outputs stay LOW while power-down holds.
- R4: With the same stimulus, `pll_en_o` falls at CPU rising edge k+3+PARK_DLY and stays 0 while power-down holds.
- R5: Every HIGH pulse and every LOW gap on an output lasts at least one full half period of its source, whatever the timing of enable changes.
- R6: An output whose bit in `out_en_i` is 0 stays LOW with no rising edges. An output whose bit is 1 follows its source while the block is running.
- R7: If `pwrdn_ni` goes HIGH before CPU rising edge m, `pll_en_o` is 1 from edge m+2. The outputs stay LOW at that edge.
- R8: After reset release, or after `pll_en_o` rises, the first rising edge on an enabled output comes between `stab_cnt_i`+2 and `stab_cnt_i`+4 reference rising edges later.
- R9: While `test_mode_i` is 1, every `clk_oe_o` bit is 0 and the clocks keep running. While it is 0, every `clk_oe_o` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | CPU clock; domain of the power-down synchronizer |
| ref_clk_i | input | 1 | Reference clock that times the stabilization wait |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrdn_ni | input | 1 | Asynchronous active-low power-down request |
| test_mode_i | input | 1 | 1 three-states all clock outputs |
| stab_cnt_i | input | STAB_W | Reference cycles to wait before outputs restart |
| src_clk_i | input | NUM_OUT | Free-running source clock for each output |
| out_en_i | input | NUM_OUT | Per-output enable, 1 = running |
| clk_o | output | NUM_OUT | Gated clock outputs |
| clk_oe_o | output | NUM_OUT | Output-driver enables, 0 = high impedance |
| pll_en_o | output | NUM_PLL | PLL enable requests |

## Verification
The bench builds the block with six outputs whose sources run at six different periods. Output 0 is driven by the CPU clock itself, so its cycle-exact parking can be sampled against the power-down edges. PARK_DLY is 3, which makes the PLL-off edge land distinctly later than the parking edge. STAB_W is 8, and stabilization values of 5 and 12 are used, so both the post-reset wait and the wake-up wait are measured against a programmed count. The slowest sources have half periods of 15 and 30 ns, which makes enable toggles land in the middle of HIGH phases, where a runt pulse would appear if gating were not aligned to falling edges.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;
  function automatic int unsigned cnt_width(int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/clk_park_pd_sync.sv
module clk_park_pd_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CONFIRM     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_ni,
  output logic accept_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + CONFIRM - 1;

  logic [DEPTH-1:0] shr_q;

  // reset value 1 = not powered down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shr_q <= '1;
    else         shr_q <= {shr_q[DEPTH-2:0], pwrdn_ni};
  end

  // accept only when CONFIRM consecutive synchronized samples are low
  assign accept_o = ~|shr_q[DEPTH-1:SYNC_STAGES-1];

  a_r2_two_low_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> ($past(!pwrdn_ni, SYNC_STAGES) && $past(!pwrdn_ni, SYNC_STAGES + 1)));
endmodule

// File: rtl/clk_park_pll_ctl.sv
module clk_park_pll_ctl #(
  parameter int unsigned PARK_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic pll_en_o
);
  localparam int unsigned W = clk_park_pkg::cnt_width(PARK_DLY);
  localparam logic [W-1:0] DLY = W'(PARK_DLY);

  logic [W-1:0] cnt_q;
  logic         pll_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      pll_en_q <= 1'b1;
    end else if (!accept_i) begin
      cnt_q    <= '0;
      pll_en_q <= 1'b1;
    end else begin
      if (cnt_q != DLY) cnt_q <= cnt_q + W'(1);
      if (cnt_q == DLY) pll_en_q <= 1'b0;
    end
  end

  assign pll_en_o = pll_en_q;

  a_r4_pll_off_only_in_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_en_q) |-> $past(accept_i));
  a_r7_pll_on_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(accept_i) |=> pll_en_q);
endmodule

// File: rtl/clk_park_stab.sv
module clk_park_stab #(
  parameter int unsigned STAB_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pll_en_i,
  input  logic [STAB_W-1:0] stab_cnt_i,
  output logic              stable_o
);
  logic [1:0]        pe_q;
  logic [STAB_W-1:0] cnt_q;
  logic              stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_q     <= '0;
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else begin
      pe_q <= {pe_q[0], pll_en_i};
      if (!pe_q[1]) begin
        cnt_q    <= '0;
        stable_q <= 1'b0;
      end else begin
        stable_q <= (cnt_q >= stab_cnt_i);
        if (cnt_q < stab_cnt_i) cnt_q <= cnt_q + STAB_W'(1);
      end
    end
  end

  assign stable_o = stable_q;

  a_r8_count_reached: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_q) |-> ($past(cnt_q) >= $past(stab_cnt_i)));
  a_r8_pll_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_q[1] |=> (!stable_q && cnt_q == '0));
endmodule

// File: rtl/clk_park_gate.sv
module clk_park_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable changes only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/clk_park_unit.sv
module clk_park_unit #(
  parameter int unsigned NUM_OUT     = 31,
  parameter int unsigned NUM_PLL     = 2,
  parameter int unsigned PARK_DLY    = 3,
  parameter int unsigned STAB_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CONFIRM     = 2
) (
  input  logic               cpu_clk_i,
  input  logic               ref_clk_i,
  input  logic               rst_ni,
  input  logic               pwrdn_ni,
  input  logic               test_mode_i,
  input  logic [STAB_W-1:0]  stab_cnt_i,
  input  logic [NUM_OUT-1:0] src_clk_i,
  input  logic [NUM_OUT-1:0] out_en_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o,
  output logic [NUM_PLL-1:0] pll_en_o
);
  logic accept;
  logic pll_en;
  logic stable;
  logic run;

  clk_park_pd_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .CONFIRM    (CONFIRM)
  ) u_sync (
    .clk_i   (cpu_clk_i),
    .rst_ni  (rst_ni),
    .pwrdn_ni(pwrdn_ni),
    .accept_o(accept)
  );

  clk_park_pll_ctl #(
    .PARK_DLY(PARK_DLY)
  ) u_pll (
    .clk_i   (cpu_clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .pll_en_o(pll_en)
  );

  clk_park_stab #(
    .STAB_W(STAB_W)
  ) u_stab (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .pll_en_i  (pll_en),
    .stab_cnt_i(stab_cnt_i),
    .stable_o  (stable)
  );

  assign run = ~accept & stable;

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
    clk_park_gate u_gate (
      .clk_i (src_clk_i[gi]),
      .rst_ni(rst_ni),
      .en_i  (run & out_en_i[gi]),
      .clk_o (clk_o[gi])
    );
  end

  assign clk_oe_o = {NUM_OUT{~test_mode_i}};
  assign pll_en_o = {NUM_PLL{pll_en}};
endmodule

// File: tb/clk_park_unit_bench.sv
`timescale 1ns/1ps

module clk_watch #(
  parameter real HALF_NS = 4.0
) (
  input  logic sig_i,
  output int   rises_o,
  output int   runts_o
);
  int      rises = 0;
  int      runt_hi = 0;
  int      runt_lo = 0;
  realtime t_rise = 0.0;
  realtime t_fall = 0.0;
  bit      seen_rise = 0;
  bit      seen_fall = 0;

  always @(posedge sig_i) begin
    rises++;
    if (seen_fall && ($realtime - t_fall) < HALF_NS - 0.01) runt_lo++;
    t_rise    = $realtime;
    seen_rise = 1;
  end

  always @(negedge sig_i) begin
    if (seen_rise && ($realtime - t_rise) < HALF_NS - 0.01) runt_hi++;
    t_fall    = $realtime;
    seen_fall = 1;
  end

  assign rises_o = rises;
  assign runts_o = runt_hi + runt_lo;
endmodule

module clk_park_unit_bench;
  localparam int N  = 6;
  localparam int NP = 2;
  localparam int SW = 8;
  localparam int PD = 3;

  function automatic real half_of(int i);
    case (i)
      0: return 4.0;
      1: return 5.0;
      2: return 7.0;
      3: return 15.0;
      4: return 30.0;
      default: return 10.0;
    endcase
  endfunction

  logic clk = 0, ref_clk = 0;
  logic s1 = 0, s2 = 0, s3 = 0, s4 = 0, s5 = 0;
  logic rst_ni = 0, pwrdn_ni = 1, test_mode = 0;
  logic [SW-1:0] stab_cnt = 8'd5;
  logic [N-1:0]  out_en = '1;
  logic [N-1:0]  src, clk_o, clk_oe;
  logic [NP-1:0] pll_en;

  always #4.0  clk = ~clk;
  always #35.0 ref_clk = ~ref_clk;
  always #5.0  s1 = ~s1;
  always #7.0  s2 = ~s2;
  always #15.0 s3 = ~s3;
  always #30.0 s4 = ~s4;
  always #10.0 s5 = ~s5;
  assign src = {s5, s4, s3, s2, s1, clk};

  clk_park_unit #(
    .NUM_OUT(N), .NUM_PLL(NP), .PARK_DLY(PD), .STAB_W(SW)
  ) u_clk_park_unit (
    .cpu_clk_i(clk), .ref_clk_i(ref_clk), .rst_ni(rst_ni), .pwrdn_ni(pwrdn_ni),
    .test_mode_i(test_mode), .stab_cnt_i(stab_cnt), .src_clk_i(src),
    .out_en_i(out_en), .clk_o(clk_o), .clk_oe_o(clk_oe), .pll_en_o(pll_en)
  );

  int rises [N];
  int runts [N];
  for (genvar gi = 0; gi < N; gi++) begin : g_watch
    clk_watch #(.HALF_NS(half_of(gi))) u_w (
      .sig_i(clk_o[gi]), .rises_o(rises[gi]), .runts_o(runts[gi]));
  end

  int ref_edges = 0;
  int pe_rise_ref = 0;
  always @(posedge ref_clk) ref_edges++;
  always @(posedge pll_en[0]) pe_rise_ref = ref_edges;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(string req, string what, longint act, longint lo, longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic t_reset();
    #20;
    chk("R1", "clk_o in reset", clk_o, 0);
    chk("R1", "pll_en in reset", pll_en, 2'b11);
    chk("R1", "clk_oe in reset", clk_oe, 6'h3f);
    #33 rst_ni = 1;
    pe_rise_ref = ref_edges;
    #2 chk("R8", "clk_o parked before stabilization", clk_o, 0);
    @(posedge clk_o[0]);
    chk_range("R8", "ref edges to first output after reset", ref_edges - pe_rise_ref, 7, 9);
  endtask

  task automatic t_enables();
    int snap [N];
    #300;
    foreach (snap[i]) snap[i] = rises[i];
    #600;
    for (int i = 0; i < N; i++) chk("R6", $sformatf("out%0d runs", i), rises[i] > snap[i], 1);
    #3 out_en = 6'b110101;
    #100;
    foreach (snap[i]) snap[i] = rises[i];
    #600;
    chk("R6", "out1 disabled rises", rises[1] - snap[1], 0);
    chk("R6", "out3 disabled rises", rises[3] - snap[3], 0);
    chk("R6", "out1 disabled level", clk_o[1], 0);
    chk("R6", "out3 disabled level", clk_o[3], 0);
    chk("R6", "out4 still runs", rises[4] > snap[4], 1);
    out_en = '1;
    #100;
    foreach (snap[i]) snap[i] = rises[i];
    #600;
    chk("R6", "out3 re-enabled runs", rises[3] > snap[3], 1);
  endtask

  task automatic t_glitch();
    for (int i = 0; i < 60; i++) begin
      #7.3 out_en = out_en ^ 6'b111110;
    end
    out_en = '1;
    #200;
    for (int i = 0; i < N; i++) chk("R5", $sformatf("out%0d runts", i), runts[i], 0);
  endtask

  task automatic t_test_mode();
    int snap;
    #3 test_mode = 1;
    #1 chk("R9", "clk_oe in test mode", clk_oe, 0);
    snap = rises[0];
    #100 chk("R9", "clock runs in test mode", rises[0] > snap, 1);
    test_mode = 0;
    #1 chk("R9", "clk_oe after test mode", clk_oe, 6'h3f);
  endtask

  task automatic t_pd_pulse();
    @(posedge clk); #2 pwrdn_ni = 0;
    @(posedge clk); #2 pwrdn_ni = 1;
    for (int j = 0; j < 8; j++) begin
      @(posedge clk); #2;
      chk("R2", $sformatf("pll_en after pulse cycle %0d", j), pll_en[0], 1);
      chk("R2", $sformatf("cpu output after pulse cycle %0d", j), clk_o[0], 1);
    end
  endtask

  task automatic t_pd_enter();
    @(posedge clk); #2 pwrdn_ni = 0;
    for (int j = 0; j <= 3 + PD; j++) begin
      @(posedge clk); #2;
      chk("R3", $sformatf("cpu output at k+%0d", j), clk_o[0], (j <= 2) ? 1 : 0);
      chk("R4", $sformatf("pll_en at k+%0d", j), pll_en[0], (j < 3 + PD) ? 1 : 0);
    end
    repeat (60) @(posedge clk);
    #3;
    chk("R3", "all outputs parked", clk_o, 0);
    chk("R4", "pll stays off", pll_en, 0);
  endtask

  task automatic t_pd_release();
    stab_cnt = 8'd12;
    @(posedge clk); #2 pwrdn_ni = 1;
    for (int j = 0; j <= 2; j++) begin
      @(posedge clk); #2;
      chk("R7", $sformatf("pll_en at m+%0d", j), pll_en[0], (j == 2) ? 1 : 0);
    end
    chk("R7", "outputs still parked at m+2", clk_o, 0);
    @(posedge clk_o[0]);
    chk_range("R8", "ref edges from pll_en to first output", ref_edges - pe_rise_ref, 14, 16);
    #400;
    for (int i = 0; i < N; i++) chk("R5", $sformatf("out%0d runts final", i), runts[i], 0);
  endtask

  initial begin
    t_reset();
    t_enables();
    t_glitch();
    t_test_mode();
    t_pd_pulse();
    t_pd_enter();
    t_pd_release();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8.0 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule